// File: doc/BRIEF.md
# Wide-Word Pseudo-Random Sequence Generator

This block produces a pseudo-random bit stream from the trinomial x^63 + x^62 + 1, delivering 64 fresh bits on every clock in which it is told to advance. A 64-bit state register holds the current word, which is also the output. The next word is the state moved forward by 64 single-bit steps of the recurrence. These steps are computed in one clock by two chained combinational 32-bit half-steps.

A user resets the block or loads a seed, then holds `step` high for as many cycles as it needs words. The block raises `rnd_valid` for one cycle after each advance. A seed that would lock the sequence at zero is swapped for a fixed nonzero constant.

Top module: `prng64_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes RESET_SEED (default 64'h9E3779B97F4A7C15) and `rnd_valid` goes low; reset wins over every other input.
- R2: With `rst` low and `load` high, the state takes `seed` at the edge and `rnd_valid` is low in the following cycle.
- R3: A loaded seed whose bits 62 down to 0 are all zero (bit 63 may be either value) is replaced by ZERO_SEED (default 64'h0123456789ABCDEF).
- R4: One serial step moves the state left by one bit, drops bit 63, and puts bit62 XOR bit61 into bit 0. An enabled advance (`step` high, `load` and `rst` low) replaces the state with the result of 64 serial steps.
- R5: After an advance, bits 63..32 of the new word equal bits 62..31 XOR bits 61..30 of the previous word.
- R6: `rnd_valid` is high in exactly those cycles that follow an enabled advance.
- R7: While `step`, `load` and `rst` are all low, `rnd` keeps its value.
- R8: When `load` and `step` are both high, the seed is loaded, no advance happens, and `rnd_valid` is low.
- R9: Once reset has been applied, bits 62..0 of the state are never all zero.
- R10: Bit 63 of the state has no effect on the next word. Two states that differ only in bit 63 advance to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Load `seed` into the state |
| seed | input | 64 | Seed value for a load |
| step | input | 1 | Advance the state by 64 bit-steps |
| rnd | output | 64 | Current state word |
| rnd_valid | output | 1 | High in the cycle after an advance |

## Verification
The assertions assume that `rst` is high from time zero until the first clock edge, so the state is always defined when they are evaluated. They also assume that `load`, `step` and `seed` are never unknown outside reset. The stimulus drives every input to a known value before releasing reset and changes inputs only on the falling edge. Expected words come from a bit-serial model stepped 64 times per word, which is checked against outputs that are sampled a half cycle after each update.

// File: rtl/prng64_gen.sv
module prng64_gen #(
  parameter logic [63:0] RESET_SEED = 64'h9E37_79B9_7F4A_7C15,
  parameter logic [63:0] ZERO_SEED  = 64'h0123_4567_89AB_CDEF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [63:0] seed,
  input  logic        step,
  output logic [63:0] rnd,
  output logic        rnd_valid
);
  localparam int W      = 64;
  localparam int HALF   = W / 2;
  localparam int STAGES = 2;

  function automatic logic [W-1:0] half_step(input logic [W-1:0] s);
    logic [W-1:0] mix;
    mix = (s << 1) ^ (s << 2);
    return (s << HALF) | (mix >> HALF);
  endfunction

  logic [W-1:0] state;
  logic [W-1:0] stage [STAGES+1];
  logic [W-1:0] seed_fix;
  logic         adv;

  assign stage[0] = state;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_half
      assign stage[g+1] = half_step(stage[g]);
    end
  endgenerate

  assign seed_fix = (seed[W-2:0] == '0) ? ZERO_SEED : seed;
  assign adv      = step & ~load;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RESET_SEED;
      rnd_valid <= 1'b0;
    end else begin
      rnd_valid <= adv;
      if (load)     state <= seed_fix;
      else if (adv) state <= stage[STAGES];
    end
  end

  assign rnd = state;
endmodule

// File: rtl/prng64_gen_chk.sv
module prng64_gen_chk #(
  parameter logic [63:0] ZERO_SEED = 64'h0123_4567_89AB_CDEF
) (
  input logic        clk,
  input logic        rst,
  input logic        load,
  input logic [63:0] seed,
  input logic        step,
  input logic [63:0] rnd,
  input logic        rnd_valid
);
  // R2
  load_seed_chk: assert property (@(posedge clk) disable iff (rst)
    (load && seed[62:0] != '0) |=> (rnd == $past(seed) && !rnd_valid));

  // R3
  zero_seed_chk: assert property (@(posedge clk) disable iff (rst)
    (load && seed[62:0] == '0) |=> (rnd == ZERO_SEED));

  // R5
  upper_half_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (rnd[63:32] == ($past(rnd[62:31]) ^ $past(rnd[61:30]))));

  // R6
  valid_set_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> rnd_valid);

  // R6
  valid_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (!step || load) |=> !rnd_valid);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(rnd));

  // R9
  no_lock_chk: assert property (@(posedge clk) disable iff (rst)
    rnd[62:0] != '0);
endmodule

bind prng64_gen prng64_gen_chk #(.ZERO_SEED(ZERO_SEED)) u_chk (
  .clk(clk), .rst(rst), .load(load), .seed(seed),
  .step(step), .rnd(rnd), .rnd_valid(rnd_valid)
);

// File: tb/prng64_gen_tb.sv
`timescale 1ns/1ps
module prng64_gen_tb_top;
  localparam logic [63:0] RST_V  = 64'h9E37_79B9_7F4A_7C15;
  localparam logic [63:0] ZERO_V = 64'h0123_4567_89AB_CDEF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic step = 1'b0;
  logic [63:0] seed = '0;
  logic [63:0] rnd;
  logic rnd_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  prng64_gen dut_i (
    .clk(clk), .rst(rst), .load(load), .seed(seed),
    .step(step), .rnd(rnd), .rnd_valid(rnd_valid)
  );

  function automatic logic [63:0] ref_adv(input logic [63:0] s);
    logic [63:0] t = s;
    for (int i = 0; i < 64; i++) t = {t[62:0], t[62] ^ t[61]};
    return t;
  endfunction

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one clock: inputs set on falling edge, results read on next falling edge
  task automatic cyc(input logic r, input logic l, input logic s, input logic [63:0] sd);
    @(negedge clk);
    rst = r; load = l; step = s; seed = sd;
    @(negedge clk);
    rst = 1'b0; load = 1'b0; step = 1'b0;
  endtask

  task automatic t_reset();
    cyc(1'b1, 1'b1, 1'b1, 64'h1);
    chk64("R1 reset state", rnd, RST_V);
    chk1("R1 reset valid", rnd_valid, 1'b0);
  endtask

  task automatic t_load();
    cyc(1'b0, 1'b1, 1'b0, 64'hDEAD_BEEF_CAFE_F00D);
    chk64("R2 load", rnd, 64'hDEAD_BEEF_CAFE_F00D);
    chk1("R2 valid low", rnd_valid, 1'b0);
  endtask

  task automatic t_zero_seed();
    cyc(1'b0, 1'b1, 1'b0, 64'h0);
    chk64("R3 zero seed", rnd, ZERO_V);
    cyc(1'b0, 1'b1, 1'b0, 64'h8000_0000_0000_0000);
    chk64("R3 bit63-only seed", rnd, ZERO_V);
    cyc(1'b0, 1'b1, 1'b0, 64'h0000_0000_0000_0001);
    chk64("R3 minimal nonzero kept", rnd, 64'h1);
  endtask

  task automatic t_stream(input logic [63:0] s0, input int n);
    logic [63:0] exp;
    cyc(1'b0, 1'b1, 1'b0, s0);
    exp = rnd;
    @(negedge clk);
    step = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      exp = ref_adv(exp);
      chk64("R4 word", rnd, exp);
      chk1("R6 valid", rnd_valid, 1'b1);
    end
    step = 1'b0;
    @(negedge clk);
    chk1("R6 valid drops", rnd_valid, 1'b0);
    chk1("R9 no lock", (rnd[62:0] != '0), 1'b1);
  endtask

  task automatic t_upper();
    logic [63:0] prev;
    cyc(1'b0, 1'b1, 1'b0, 64'hF0F0_1234_5678_0F0F);
    prev = rnd;
    cyc(1'b0, 1'b0, 1'b1, 64'h0);
    chk64("R5 upper half", {32'h0, rnd[63:32]}, {32'h0, prev[62:31] ^ prev[61:30]});
  endtask

  task automatic t_hold();
    logic [63:0] prev;
    cyc(1'b0, 1'b0, 1'b1, 64'h0);
    prev = rnd;
    repeat (3) @(negedge clk);
    chk64("R7 hold", rnd, prev);
    chk1("R7 valid low", rnd_valid, 1'b0);
  endtask

  task automatic t_priority();
    cyc(1'b0, 1'b1, 1'b1, 64'h1111_2222_3333_4444);
    chk64("R8 load over step", rnd, 64'h1111_2222_3333_4444);
    chk1("R8 valid low", rnd_valid, 1'b0);
    cyc(1'b1, 1'b1, 1'b1, 64'h5555);
    chk64("R1 reset over load", rnd, RST_V);
  endtask

  task automatic t_bit63();
    logic [63:0] a;
    logic [63:0] b;
    cyc(1'b0, 1'b1, 1'b0, 64'h0ABC_DEF0_1357_9BDF);
    cyc(1'b0, 1'b0, 1'b1, 64'h0);
    a = rnd;
    cyc(1'b0, 1'b1, 1'b0, 64'h8ABC_DEF0_1357_9BDF);
    cyc(1'b0, 1'b0, 1'b1, 64'h0);
    b = rnd;
    chk64("R10 bit63 ignored", b, a);
    chk64("R10 matches model", a, ref_adv(64'h0ABC_DEF0_1357_9BDF));
  endtask

  task automatic t_gap();
    logic [63:0] exp;
    cyc(1'b0, 1'b1, 1'b0, 64'h0F1E_2D3C_4B5A_6978);
    exp = ref_adv(ref_adv(64'h0F1E_2D3C_4B5A_6978));
    cyc(1'b0, 1'b0, 1'b1, 64'h0);
    chk1("R6 valid after step", rnd_valid, 1'b1);
    @(negedge clk);
    chk1("R6 valid gap", rnd_valid, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 64'h0);
    chk64("R4 word across gap", rnd, exp);
  endtask

  initial begin
    t_reset();
    t_load();
    t_zero_seed();
    t_stream(64'hACE1_0000_0000_0001, 8);
    t_stream(64'h7FFF_FFFF_FFFF_FFFF, 5);
    t_stream(64'h0, 300);
    t_upper();
    t_hold();
    t_priority();
    t_bit63();
    t_gap();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule